// File: doc/BRIEF.md
# Watchdog Countdown Timer with Register Window

This block is a watchdog countdown timer that software controls through a small 32-bit register window. Software programs a timeout in ticks into a count word. It sets a run bit to let the timer count and writes a reload bit at intervals to restart the countdown. The count advances only on cycles where the tick-enable input is high. That strobe comes from a shared timebase, commonly one pulse per second.

If the countdown runs out before software reloads it, the block latches a sticky fired flag. It then emits a single-cycle request on one of two outputs: system reset or shutdown, picked by an action bit in the control word. After expiry the timer stays idle until the next reload. A strap input can lock the block out entirely. While the strap is high the block does not count, and software can see the strap state in the control word.

Top module: `wdt_unit`

## Requirements
- R1: After reset the control word reads 0 apart from bit 3, which equals the strap input. The count word reads 0x0000FFFF, and both request outputs are low.
- R2: Byte offset 0x0 selects the control word and offset 0x4 the count word. The count word keeps bits 15:0 of a write, and its bits 31:16 read as 0. Any other offset reads as 0 and ignores writes.
- R3: Writing the control word with bit 7 set loads the countdown from the count word and arms it. Bit 7 always reads 0, and bits 6:4 and 31:8 read as 0 whatever is written.
- R4: The countdown decrements on each tick only when bit 0 (run) is 1, the strap is low and the timer is armed. With a timeout of N it expires on the N-th such tick after a reload, and a timeout of 0 behaves like 1.
- R5: On expiry, bit 1 (fired) becomes 1. In the following cycle, reset_req pulses for exactly one cycle if bit 2 is 0, or shutdown_req pulses if bit 2 is 1. The timer then disarms and does not expire again until reloaded.
- R6: Writing 1 to bit 1 clears the fired flag and writing 0 leaves it unchanged. If an expiry and a clearing write fall in the same cycle, the flag ends up set.
- R7: Clearing run holds the remaining count, and setting it again resumes from the held value without a reload.
- R8: Bit 3 mirrors the strap input and cannot be written. While the strap is high, no tick decrements the count and no expiry occurs.
- R9: A reload written in the same cycle as the tick that would expire the timer takes priority, so no expiry occurs.
- R10: Writing the control word 0x00000002 clears fired and leaves run at 0, so ticks produce no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Write strobe for the register window |
| reg_addr | input | 4 | Byte offset into the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tick_en | input | 1 | Countdown tick strobe |
| strap_disable | input | 1 | Hardware lockout strap |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
The bench targets the collisions between events:

- A reload that lands on the expiring tick. A design that lets the tick win would raise a spurious reset while software is servicing the timer.
- A fired-clear write that meets an expiry. A design that favours the clear loses the record of the timeout.
- A pause followed by a resume. If the count reloads on resume, expiry comes too late.
- A zero timeout. A design that wraps the count down from zero waits 65535 ticks.

A long random phase also checks that no request repeats once the timer has disarmed, and that the strap freezes counting.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  // Byte offsets of the two words in the window.
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_COUNT = 4;

  // Control word bit positions (software decodes these).
  localparam int unsigned BIT_RUN    = 0;
  localparam int unsigned BIT_FIRED  = 1;
  localparam int unsigned BIT_ACTION = 2;
  localparam int unsigned BIT_LOCK   = 3;
  localparam int unsigned BIT_RELOAD = 7;

  typedef enum logic {
    ACT_RESET    = 1'b0,
    ACT_SHUTDOWN = 1'b1
  } wdt_action_e;

  // Assemble the visible low byte of the control word.
  function automatic logic [7:0] ctrl_byte(input logic run, input logic fired,
                                           input logic act, input logic lock);
    logic [7:0] b;
    b = '0;
    b[BIT_RUN]    = run;
    b[BIT_FIRED]  = fired;
    b[BIT_ACTION] = act;
    b[BIT_LOCK]   = lock;
    return b;
  endfunction
endpackage

// File: rtl/wdt_regfile.sv
`timescale 1ns/1ps
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 16,
  parameter logic [CNT_W-1:0] CNT_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              strap_dis,
  input  logic              expire,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output wdt_action_e       action,
  output logic              fired,
  output logic              reload_pulse,
  output logic [CNT_W-1:0]  timeout
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

  logic sel_ctrl, sel_count, wr_ctrl, wr_count, clr_fired;

  assign sel_ctrl     = (addr == A_CTRL);
  assign sel_count    = (addr == A_COUNT);
  assign wr_ctrl      = wen && sel_ctrl;
  assign wr_count     = wen && sel_count;
  assign clr_fired    = wr_ctrl && wdata[BIT_FIRED];
  assign reload_pulse = wr_ctrl && wdata[BIT_RELOAD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      action  <= ACT_RESET;
      fired   <= 1'b0;
      timeout <= CNT_RST;
    end else begin
      if (wr_ctrl) begin
        run    <= wdata[BIT_RUN];
        action <= wdt_action_e'(wdata[BIT_ACTION]);
      end
      if (expire)         fired <= 1'b1;
      else if (clr_fired) fired <= 1'b0;
      if (wr_count) timeout <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl)       rdata[7:0]       = ctrl_byte(run, fired, action, strap_dis);
    else if (sel_count) rdata[CNT_W-1:0] = timeout;
  end

  wire unused_wbits = ^{wdata[DATA_W-1:CNT_W], wdata[6:4]};

  // R6: fired only drops on a write-one-to-clear.
  p_fired_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fired && !clr_fired |=> fired);
  // R6: an expiry in the same cycle as a clear leaves the flag set.
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> fired);
  // R2: the count word only moves on a write to its own offset.
  p_count_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_count |=> $stable(timeout));
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             strap_dis,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] timeout,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             step;

  // A count of 0 or 1 means the present tick is the last one.
  function automatic logic last_tick(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] c);
    return last_tick(c) ? '0 : c - CNT_W'(1);
  endfunction

  assign step   = run && !strap_dis && armed && tick;
  assign expire = step && last_tick(cnt) && !reload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (reload) begin
      cnt   <= timeout;
      armed <= 1'b1;
    end else if (step) begin
      cnt <= dec_sat(cnt);
      if (last_tick(cnt)) armed <= 1'b0;
    end
  end

  // R8: the strap freezes the count.
  p_hold_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strap_dis && !reload |=> $stable(cnt));
  // R7: a stopped timer keeps its remaining count.
  p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !reload |=> $stable(cnt));
  // R3: a reload loads the programmed timeout and arms.
  p_reload_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(timeout)) && armed);
  // R5: after expiry the timer is disarmed.
  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed);
endmodule

// File: rtl/wdt_alarm.sv
`timescale 1ns/1ps
module wdt_alarm
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        expire,
  input  wdt_action_e action,
  output logic        reset_req,
  output logic        shutdown_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_req    <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      reset_req    <= expire && (action == ACT_RESET);
      shutdown_req <= expire && (action == ACT_SHUTDOWN);
    end
  end

  // R5: never both requests at once.
  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_req && shutdown_req));
  // R5: each request is a single-cycle pulse.
  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  p_shd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);
endmodule

// File: rtl/wdt_unit.sv
`timescale 1ns/1ps
module wdt_unit
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_en,
  input  logic              strap_disable,
  output logic              reset_req,
  output logic              shutdown_req
);
  localparam logic [CNT_W-1:0] CNT_RST = '1;

  logic             run, fired, reload_pulse, expire;
  wdt_action_e      action;
  logic [CNT_W-1:0] timeout;

  wdt_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .strap_dis(strap_disable), .expire(expire), .rdata(reg_rdata), .run(run),
    .action(action), .fired(fired), .reload_pulse(reload_pulse), .timeout(timeout)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .strap_dis(strap_disable), .tick(tick_en),
    .reload(reload_pulse), .timeout(timeout), .expire(expire)
  );

  wdt_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .expire(expire), .action(action),
    .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  // R9: a reload never coincides with an expiry.
  p_reload_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |=> !reset_req && !shutdown_req);
  // R4: nothing expires without a tick.
  p_tick_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !reset_req && !shutdown_req);
  // R5: a request follows only once fired is set.
  p_req_fired_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || shutdown_req) |-> fired);
endmodule

// File: tb/tb_wdt_unit.sv
`timescale 1ns/1ps
module tb_wdt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_en = 1'b0;
  logic        strap = 1'b0;
  logic        reset_req, shutdown_req;

  always #2.5 clk = ~clk;

  wdt_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
    .strap_disable(strap), .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model, kept from the requirements.
  logic        m_run, m_act, m_fired, m_armed, m_rst, m_shd;
  logic [15:0] m_to, m_cnt;
  logic        seen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_ctrl();
    return {28'd0, strap, m_act, m_fired, m_run};
  endfunction

  function automatic logic [15:0] after_tick(input logic [15:0] c);
    if (c == 16'd0 || c == 16'd1) return 16'd0;
    return c - 16'd1;
  endfunction

  task automatic model_reset();
    m_run = 0; m_act = 0; m_fired = 0; m_armed = 0; m_rst = 0; m_shd = 0;
    m_to = 16'hFFFF; m_cnt = 0;
  endtask

  // One clock: drive, advance model, check request outputs.
  task automatic cyc(input logic wen, input logic [3:0] a, input logic [31:0] d, input logic tk);
    logic wc, wn, rl, dec, ex;
    reg_wen = wen; reg_addr = a; reg_wdata = d; tick_en = tk;
    wc  = wen && (a == 4'h0);
    wn  = wen && (a == 4'h4);
    rl  = wc && d[7];
    dec = m_run && !strap && m_armed && tk;
    ex  = dec && (m_cnt <= 16'd1) && !rl;
    @(posedge clk);
    #1;
    m_rst = ex && !m_act;
    m_shd = ex && m_act;
    if (rl) begin m_cnt = m_to; m_armed = 1; end
    else if (dec) begin
      if (m_cnt <= 16'd1) m_armed = 0;
      m_cnt = after_tick(m_cnt);
    end
    if (ex) m_fired = 1;
    else if (wc && d[1]) m_fired = 0;
    if (wc) begin m_run = d[0]; m_act = d[2]; end
    if (wn) m_to = d[15:0];
    reg_wen = 0; tick_en = 0;
    if (reset_req || shutdown_req) seen = 1;
    chk("R5 reset_req", {31'd0, reset_req}, {31'd0, m_rst});
    chk("R5 shutdown_req", {31'd0, shutdown_req}, {31'd0, m_shd});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d); cyc(1, a, d, 0); endtask
  task automatic tk(); cyc(0, 4'h0, 0, 1); endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tk();
  endtask

  initial begin
    #750000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20250607));
    model_reset();
    seen = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
    rd(4'h4, v); chk("R1 count", v, 32'h0000FFFF);
    chk("R1 outputs", {30'd0, reset_req, shutdown_req}, 32'd0);
    strap = 1; rd(4'h0, v); chk("R1 lock bit", v, 32'h8); strap = 0;

    // R2 map
    wr(4'h4, 32'hABCD1234); rd(4'h4, v); chk("R2 count upper bits", v, 32'h1234);
    wr(4'h8, 32'hFFFFFFFF); rd(4'h8, v); chk("R2 unmapped read", v, 0);
    rd(4'h0, v); chk("R2 unmapped write ctrl", v, 0);
    rd(4'h4, v); chk("R2 unmapped write count", v, 32'h1234);

    // R3 reserved / reload read as 0, lock not writable (R8)
    wr(4'h0, 32'hFFFFFFFF); rd(4'h0, v); chk("R3 read mask", v, 32'h5);
    // R10 init word
    wr(4'h0, 32'h2); rd(4'h0, v); chk("R10 init", v, 0);
    seen = 0; ticks(8); chk("R10 no expiry", {31'd0, seen}, 0);

    // R4/R5 expiry on Nth tick, reset action
    wr(4'h4, 3); wr(4'h0, 32'h81);
    seen = 0; ticks(2); chk("R4 early", {31'd0, seen}, 0);
    tk(); chk("R5 reset pulse", {31'd0, reset_req}, 1);
    rd(4'h0, v); chk("R5 fired", v, 32'h3);
    seen = 0; ticks(6); chk("R5 disarmed", {31'd0, seen}, 0);

    // R6 W1C
    wr(4'h0, 32'h1); rd(4'h0, v); chk("R6 write0 keeps", v, 32'h3);
    wr(4'h0, 32'h3); rd(4'h0, v); chk("R6 write1 clears", v, 32'h1);

    // R5 shutdown action
    wr(4'h4, 2); wr(4'h0, 32'h85); tk();
    tk(); chk("R5 shutdown pulse", {30'd0, reset_req, shutdown_req}, 32'h1);

    // R7 pause and resume
    wr(4'h0, 32'h2); wr(4'h4, 5); wr(4'h0, 32'h81); ticks(2);
    wr(4'h0, 32'h0); seen = 0; ticks(10); chk("R7 paused", {31'd0, seen}, 0);
    wr(4'h0, 32'h1); ticks(2); chk("R7 resumed early", {31'd0, seen}, 0);
    tk(); chk("R7 resume expiry", {31'd0, reset_req}, 1);

    // R8 strap
    wr(4'h0, 32'h2); strap = 1; wr(4'h4, 1); wr(4'h0, 32'h89);
    rd(4'h0, v); chk("R8 lock reads strap", v, 32'h9);
    seen = 0; ticks(6); chk("R8 frozen", {31'd0, seen}, 0);
    strap = 0; rd(4'h0, v); chk("R8 lock not written", v, 32'h1);
    tk(); chk("R8 counts after release", {31'd0, reset_req}, 1);

    // R4 zero timeout acts as one
    wr(4'h0, 32'h2); wr(4'h4, 0); wr(4'h0, 32'h81);
    tk(); chk("R4 zero timeout", {31'd0, reset_req}, 1);

    // R9 reload beats expiring tick
    wr(4'h4, 1); wr(4'h0, 32'h81);
    seen = 0; cyc(1, 4'h0, 32'h81, 1); chk("R9 reload wins", {31'd0, seen}, 0);
    tk(); chk("R9 later expiry", {31'd0, reset_req}, 1);

    // R6 set beats simultaneous clear
    wr(4'h0, 32'h3); wr(4'h0, 32'h81);
    cyc(1, 4'h0, 32'h3, 1); rd(4'h0, v); chk("R6 set wins", v, 32'h3);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [31:0] d;
      op = $urandom % 10;
      d  = $urandom;
      if ($urandom % 200 == 0) strap = ~strap;
      case (op)
        0, 1:    cyc(1, 4'h0, (d & 32'hFFFFFF7F) | ((d[9:8] != 0) ? 32'h80 : 0), d[12]);
        2:       cyc(1, 4'h4, {d[31:16], 13'd0, d[2:0]}, d[12]);
        3:       cyc(1, 4'h8 | {2'b0, d[1:0]}, d, d[12]);
        default: cyc(0, 4'h0, 0, d[12] | d[13]);
      endcase
      if (i % 5 == 0) begin
        rd(4'h0, v); chk("R3 R6 ctrl readback", v, exp_ctrl());
        rd(4'h4, v); chk("R2 count readback", v, {16'd0, m_to});
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule